// File: doc/BRIEF.md
# Paged Training and Status Register Readout

This block stands beside a DRAM data path and answers reads from a small set of register pages instead of from the memory array. There are four pages and each page holds four byte-wide locations. A page-mode input turns the feature on. A 2-bit page select picks one of the four pages, and a 2-bit location field, taken from the bank address bits of the command, picks one byte within that page.

Page 0 holds a training pattern that software can overwrite. Page 1 shows a 32-bit command/address parity error log that another block supplies. Page 2 shows configuration bits that the mode logic supplies. In location 0 of page 2, two of those bits are replaced by a refresh-rate status field, and that field follows a temperature input only while temperature readout is enabled. Page 3 is kept for vendor use and always reads as zero.

A read returns eight beats on eight data lanes. The readout format is one of three: serial, where the byte goes out one bit per beat; parallel, where the whole byte appears on every beat; and staggered, where each lane carries a different location.

Top module: `regpage_readout`

## Requirements
- R1: After reset, no beat is valid, page 0 holds 0x55, 0x33, 0x0F and 0x00 in locations 0 to 3, and the refresh status field holds 01.
- R2: A read command is taken only when pageMode is 1 and no burst is in progress. A read with pageMode 0, or a read that arrives during a burst, produces no beats and does not change the burst in progress.
- R3: A read that is taken produces beatValid for exactly 8 consecutive cycles, beginning in the cycle after the command edge. beatLast is high only on the eighth beat.
- R4: cmdLoc (values 0 to 3) selects the location. The page, location, format and page contents are captured at the command edge.
- R5: A write command with pageMode 1 and pageSel 00 stores wrData into page 0 at cmdLoc.
- R6: A write that targets page 1, 2 or 3, or that arrives with pageMode 0, is ignored and leaves page 0 unchanged.
- R7: Page 1, location n, returns errLog[8n+7:8n].
- R8: Page 2, location n, returns cfgMirror[8n+7:8n], except that bits 4:3 of location 0 carry the refresh status field.
- R9: The refresh status field loads refreshStatus on every clock while tempEnable is 1 and holds its value while tempEnable is 0. The encoding is 00 = below 1x, 01 = 1x, 10 = 2x, 11 = reserved.
- R10: With fmtSel 00 (serial), beat k drives bit 7-k of the selected byte on all 8 lanes.
- R11: With fmtSel 01 (parallel), every beat drives the whole selected byte, with lane i carrying bit i.
- R12: With fmtSel 10 (staggered), lanes i and i+4 (i = 0 to 3) drive, on beat k, bit 7-k of location (cmdLoc+i) mod 4.
- R13: With fmtSel 11 (reserved), every lane is 0. Page 3 reads as 0x00 in every location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| pageMode | input | 1 | 1 routes reads and writes to the register pages |
| pageSel | input | 2 | Page number 0 to 3 |
| fmtSel | input | 2 | Readout format: 00 serial, 01 parallel, 10 staggered, 11 reserved |
| tempEnable | input | 1 | Enables updates of the refresh status field |
| refreshStatus | input | 2 | Refresh rate reported by the temperature sensor |
| errLog | input | 32 | Parity error log, shown as page 1 |
| cfgMirror | input | 32 | Configuration bits, shown as page 2 |
| cmdValid | input | 1 | A command is present this cycle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdLoc | input | 2 | Location within the page, from the bank address bits |
| wrData | input | 8 | Write data for page 0 |
| beatValid | output | 1 | A burst beat is on beatData |
| beatLast | output | 1 | Final beat of the burst |
| beatData | output | 8 | Eight data lanes for the current beat |

## Verification
A corrupted page 0 cell appears as a wrong byte on the first read of that location after the fault, and in parallel format it shows on the very first beat. If the beat counter or the busy flag goes wrong, the burst length changes, beatLast moves to another beat, or a read that should be ignored starts a burst, and all of these show within the eight beats of the affected read. A refresh status that fails to hold or fails to update shows only on the next page 2 read of location 0, in bits 4:3.

// File: rtl/regpage_pkg.sv
package regpage_pkg;
  parameter int BYTE_W = 8;
  parameter int LOCS = 4;
  parameter int BEATS = 8;
  localparam int LOC_W = $clog2(LOCS);
  localparam int BEAT_W = $clog2(BEATS);

  typedef enum logic [1:0] {
    FMT_SERIAL = 2'b00,
    FMT_PARALLEL = 2'b01,
    FMT_STAGGER = 2'b10,
    FMT_RSVD = 2'b11
  } fmt_e;

  typedef struct packed {
    logic takeRead;
    logic writeP0;
    logic active;
    logic [BEAT_W-1:0] beat;
  } strobe_t;
endpackage

// File: rtl/regpage_ctrl.sv
module regpage_ctrl
  import regpage_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pageMode,
  input  logic [1:0] pageSel,
  input  logic cmdValid,
  input  logic cmdWrite,
  output strobe_t strobe,
  output logic lastBeat
);
  logic busy;
  logic [BEAT_W-1:0] beatCnt;
  logic takeRead;

  assign takeRead = cmdValid && !cmdWrite && pageMode && !busy;
  assign lastBeat = busy && (beatCnt == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      beatCnt <= '0;
    end else if (takeRead) begin
      busy <= 1'b1;
      beatCnt <= '0;
    end else if (lastBeat) begin
      busy <= 1'b0;
      beatCnt <= '0;
    end else if (busy) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.takeRead = takeRead;
    strobe.writeP0 = cmdValid && cmdWrite && pageMode && (pageSel == 2'b00);
    strobe.active = busy;
    strobe.beat = beatCnt;
  end

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |=> !busy); // R3
  AST_BURST_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && pageMode && !cmdWrite)); // R2
  AST_NO_READ_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !pageMode) |=> !busy); // R2
endmodule

// File: rtl/regpage_data.sv
module regpage_data
  import regpage_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t strobe,
  input  logic [1:0] pageSel,
  input  logic [1:0] fmtSel,
  input  logic tempEnable,
  input  logic [1:0] refreshStatus,
  input  logic [LOCS*BYTE_W-1:0] errLog,
  input  logic [LOCS*BYTE_W-1:0] cfgMirror,
  input  logic [LOC_W-1:0] cmdLoc,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] beatData
);
  localparam logic [LOCS*BYTE_W-1:0] PAGE0_INIT = 32'h000F3355;

  logic [BYTE_W-1:0] page0 [LOCS];
  logic [1:0] tempStat;
  logic [BYTE_W-1:0] pageView [LOCS];
  logic [BYTE_W-1:0] snap [LOCS];
  logic [LOC_W-1:0] snapLoc;
  fmt_e snapFmt;

  for (genvar g = 0; g < LOCS; g++) begin : g_loc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) page0[g] <= PAGE0_INIT[g*BYTE_W +: BYTE_W];
      else if (strobe.writeP0 && (cmdLoc == LOC_W'(g))) page0[g] <= wrData;
    end

    always_comb begin
      case (pageSel)
        2'd0: pageView[g] = page0[g];
        2'd1: pageView[g] = errLog[g*BYTE_W +: BYTE_W];
        2'd2: begin
          pageView[g] = cfgMirror[g*BYTE_W +: BYTE_W];
          if (g == 0) pageView[g][4:3] = tempStat;
        end
        default: pageView[g] = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) snap[g] <= '0;
      else if (strobe.takeRead) snap[g] <= pageView[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tempStat <= 2'b01;
    else if (tempEnable) tempStat <= refreshStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapLoc <= '0;
      snapFmt <= FMT_SERIAL;
    end else if (strobe.takeRead) begin
      snapLoc <= cmdLoc;
      snapFmt <= fmt_e'(fmtSel);
    end
  end

  logic [BEAT_W-1:0] bitIdx;
  assign bitIdx = BEAT_W'(BYTE_W - 1) - strobe.beat;

  always_comb begin
    beatData = '0;
    if (strobe.active) begin
      case (snapFmt)
        FMT_SERIAL: beatData = {BYTE_W{snap[snapLoc][bitIdx]}};
        FMT_PARALLEL: beatData = snap[snapLoc];
        FMT_STAGGER:
          for (int i = 0; i < BYTE_W; i++)
            beatData[i] = snap[LOC_W'(snapLoc + LOC_W'(i % LOCS))][bitIdx];
        default: beatData = '0;
      endcase
    end
  end

  AST_RO_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeP0) |=> $stable(page0[0]) && $stable(page0[1]) &&
                          $stable(page0[2]) && $stable(page0[3])); // R6
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tempEnable |=> $stable(tempStat)); // R9
  AST_PAR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && $past(strobe.active) && snapFmt == FMT_PARALLEL)
      |-> $stable(beatData)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> (beatData == '0)); // R3
endmodule

// File: rtl/regpage_readout.sv
module regpage_readout
  import regpage_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pageMode,
  input  logic [1:0] pageSel,
  input  logic [1:0] fmtSel,
  input  logic tempEnable,
  input  logic [1:0] refreshStatus,
  input  logic [31:0] errLog,
  input  logic [31:0] cfgMirror,
  input  logic cmdValid,
  input  logic cmdWrite,
  input  logic [1:0] cmdLoc,
  input  logic [7:0] wrData,
  output logic beatValid,
  output logic beatLast,
  output logic [7:0] beatData
);
  strobe_t strobe;

  regpage_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pageMode(pageMode), .pageSel(pageSel),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .strobe(strobe),
    .lastBeat(beatLast)
  );

  regpage_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pageSel(pageSel),
    .fmtSel(fmtSel), .tempEnable(tempEnable), .refreshStatus(refreshStatus),
    .errLog(errLog), .cfgMirror(cfgMirror), .cmdLoc(cmdLoc),
    .wrData(wrData), .beatData(beatData)
  );

  assign beatValid = strobe.active;
endmodule

// File: tb/regpage_readout_test.sv
module regpage_readout_test;
  logic clk = 0;
  logic rstN = 0;
  logic pageMode = 0;
  logic [1:0] pageSel = 0;
  logic [1:0] fmtSel = 0;
  logic tempEnable = 0;
  logic [1:0] refreshStatus = 0;
  logic [31:0] errLog = 32'hC3A5_1E7B;
  logic [31:0] cfgMirror = 32'h9ABC_DEF0;
  logic cmdValid = 0;
  logic cmdWrite = 0;
  logic [1:0] cmdLoc = 0;
  logic [7:0] wrData = 0;
  logic beatValid, beatLast;
  logic [7:0] beatData;

  int total = 0;
  int bad = 0;
  logic [7:0] p0 [4];

  regpage_readout uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expBeat(input logic [7:0] b [4], input int loc,
                                         input int fmt, input int k);
    logic [7:0] r = '0;
    case (fmt)
      0: r = {8{b[loc][7-k]}};
      1: r = b[loc];
      2: for (int i = 0; i < 8; i++) r[i] = b[(loc + i) % 4][7-k];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic doRead(input string req, input int pg, input int loc, input int fmt,
                        input logic [7:0] b [4], input bit interrupt);
    @(negedge clk);
    pageMode = 1; pageSel = 2'(pg); fmtSel = 2'(fmt); cmdLoc = 2'(loc);
    cmdWrite = 0; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    for (int k = 0; k < 8; k++) begin
      check({req, " valid"}, 32'(beatValid), 1);
      check({req, " last"}, 32'(beatLast), 32'(k == 7));
      check({req, " data"}, 32'(beatData), 32'(expBeat(b, loc, fmt, k)));
      if (interrupt && k == 2) begin
        fmtSel = 2'd3; cmdLoc = 2'd0; cmdValid = 1;
      end
      @(negedge clk);
      cmdValid = 0;
    end
    check({req, " end"}, 32'(beatValid), 0);
  endtask

  task automatic doWrite(input bit mode, input int pg, input int loc, input logic [7:0] d);
    @(negedge clk);
    pageMode = mode; pageSel = 2'(pg); cmdLoc = 2'(loc); wrData = d;
    cmdWrite = 1; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0; cmdWrite = 0;
  endtask

  task automatic testReset();
    check("R1 idle", 32'(beatValid), 0);
    for (int l = 0; l < 4; l++) doRead("R1 R4 R11 default", 0, l, 1, p0, 0);
  endtask

  task automatic testFormats();
    doRead("R10 serial", 0, 1, 0, p0, 0);
    doRead("R12 staggered", 0, 2, 2, p0, 0);
    doRead("R12 staggered wrap", 0, 3, 2, p0, 0);
    doRead("R13 reserved fmt", 0, 0, 3, p0, 0);
  endtask

  task automatic testWrites();
    logic [7:0] e [4];
    doWrite(1, 0, 3, 8'hA5); p0[3] = 8'hA5;
    doWrite(1, 0, 1, 8'h6C); p0[1] = 8'h6C;
    doRead("R5 write back", 0, 3, 1, p0, 0);
    doRead("R5 write back loc1", 0, 1, 0, p0, 0);
    doWrite(1, 1, 3, 8'hFF);
    doWrite(1, 2, 1, 8'hFF);
    doWrite(0, 0, 0, 8'hEE);
    doRead("R6 page0 unchanged", 0, 0, 1, p0, 0);
    doRead("R6 page0 unchanged loc3", 0, 3, 1, p0, 0);
    for (int l = 0; l < 4; l++) e[l] = errLog[8*l +: 8];
    doRead("R6 R7 error log", 1, 3, 1, e, 0);
  endtask

  task automatic testPages();
    logic [7:0] e [4];
    for (int l = 0; l < 4; l++) e[l] = errLog[8*l +: 8];
    doRead("R7 error log serial", 1, 2, 0, e, 0);
    for (int l = 0; l < 4; l++) e[l] = cfgMirror[8*l +: 8];
    e[0][4:3] = 2'b01;
    doRead("R8 R9 reset status", 2, 0, 1, e, 0);
    doRead("R8 mirror loc2", 2, 2, 1, e, 0);
    @(negedge clk); tempEnable = 1; refreshStatus = 2'b10;
    @(negedge clk); @(negedge clk);
    e[0][4:3] = 2'b10;
    doRead("R9 status update", 2, 0, 1, e, 0);
    tempEnable = 0; refreshStatus = 2'b00;
    @(negedge clk); @(negedge clk);
    doRead("R9 status hold", 2, 0, 1, e, 0);
    for (int l = 0; l < 4; l++) e[l] = 8'h00;
    doRead("R13 page3", 3, 1, 1, e, 0);
  endtask

  task automatic testIgnoredReads();
    @(negedge clk);
    pageMode = 0; cmdWrite = 0; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    check("R2 normal mode read", 32'(beatValid), 0);
    @(negedge clk);
    check("R2 normal mode read later", 32'(beatValid), 0);
    doRead("R2 R3 read during burst", 0, 2, 1, p0, 1);
    @(negedge clk);
    check("R2 no second burst", 32'(beatValid), 0);
  endtask

  initial begin
    p0[0] = 8'h55; p0[1] = 8'h33; p0[2] = 8'h0F; p0[3] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFormats();
    testWrites();
    testPages();
    testIgnoredReads();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule